// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive interrupt requests and enables them through a mask. When at least one enabled request is active, it selects one source and presents that source to the processor. Software programs a 32-bit vector for each source. It changes the mask only through a set command word and a clear command word. When an interrupt is taken, it reads the captured source number and the vector of the winning source.

Reading the vector word acknowledges the interrupt and drops the processor line. The controller then stays in service and does not raise a new interrupt until software writes the end-of-interrupt word. After that write, the controller looks at the pending requests again. Source 0 is routed to the fast-interrupt line and every other source to the normal-interrupt line.

The bus is a simple single-cycle register port. Read data is combinational from the word address during a read strobe. Word addresses 0 to 31 hold the source vectors, and the control words follow them.

Top module: `vic32`

## Requirements
- R1: After reset the mask reads 0, both processor lines are low, and the source word (address 35) and vector word (address 36) read 0.
- R2: Word addresses 0 to 31 are the per-source vectors. Each can be written with a 32-bit value and read back unchanged.
- R3: A write to address 32 ORs the write data into the enable mask. The mask is readable at address 34.
- R4: A write to address 33 clears the set bits of the write data from the mask. Other mask bits are kept.
- R5: A request whose mask bit is 0 never raises a processor line.
- R6: When idle and any enabled request is active, the controller captures that source on the next clock edge, lowest index first. Address 35 then reads the index, address 36 reads that source's vector, and a processor line rises at that same edge.
- R7: Source 0 drives only the fast-interrupt line (fiq_o). Sources 1 to 31 drive only the normal-interrupt line (irq_o). The two lines are never high together.
- R8: A read of address 36 while a line is high drops the line at the next edge. No new interrupt is raised before an end-of-interrupt write, even if requests stay active.
- R9: A write to address 36 is ignored. The line stays high, and the vector read back is unchanged.
- R10: A write to address 37 (end of interrupt) leaves the mask and the vectors unchanged. It ends service, and one edge later the controller re-evaluates and raises a line again if an enabled request is still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of address 36 acknowledges) |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr |
| src_req | input | NSRC | Level interrupt requests, one per source |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
A corrupted mask bit shows at the ports within two cycles. A masked source raises a line, or an enabled one stays silent, and a read of address 34 shows it at once. A wrong priority choice or a stale captured vector appears as a wrong value on the source word or vector word in the first read after the line rises. A lost in-service flag shows as a line rising again after an acknowledge and before the end-of-interrupt write, one edge after the acknowledge. A stuck flag shows as a line that never returns after end of interrupt.

// File: rtl/vic32.sv
module vic32 #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NSRC + 6)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_req,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int IW = $clog2(NSRC);
  localparam logic [AW-1:0] A_SET  = AW'(NSRC);
  localparam logic [AW-1:0] A_CLR  = AW'(NSRC + 1);
  localparam logic [AW-1:0] A_MASK = AW'(NSRC + 2);
  localparam logic [AW-1:0] A_SRC  = AW'(NSRC + 3);
  localparam logic [AW-1:0] A_VEC  = AW'(NSRC + 4);
  localparam logic [AW-1:0] A_EOI  = AW'(NSRC + 5);

  logic [DW-1:0]   vec_q [NSRC];
  logic [NSRC-1:0] mask_q;
  logic [IW-1:0]   cur_src;
  logic [DW-1:0]   cur_vec;
  logic            insvc_q, line_q;
  logic [IW-1:0]   win;

  wire [NSRC-1:0] pend = src_req & mask_q;
  wire do_ack = bus_rd && (bus_addr == A_VEC) && line_q;
  wire do_eoi = bus_wr && (bus_addr == A_EOI);

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) win = IW'(i);
  end

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_vec
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) vec_q[g] <= '0;
        else if (bus_wr && bus_addr == AW'(g)) vec_q[g] <= bus_wdata;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '0;
    else if (bus_wr && bus_addr == A_SET) mask_q <= mask_q | bus_wdata[NSRC-1:0];
    else if (bus_wr && bus_addr == A_CLR) mask_q <= mask_q & ~bus_wdata[NSRC-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      insvc_q <= 1'b0;
      line_q  <= 1'b0;
      cur_src <= '0;
      cur_vec <= '0;
    end else if (do_eoi) begin
      insvc_q <= 1'b0;
      line_q  <= 1'b0;
    end else if (do_ack) begin
      line_q  <= 1'b0;
    end else if (!insvc_q && |pend) begin
      insvc_q <= 1'b1;
      line_q  <= 1'b1;
      cur_src <= win;
      cur_vec <= vec_q[win];
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr < A_SET) bus_rdata = vec_q[bus_addr[IW-1:0]];
      else if (bus_addr == A_MASK) bus_rdata = DW'(mask_q);
      else if (bus_addr == A_SRC)  bus_rdata = DW'(cur_src);
      else if (bus_addr == A_VEC)  bus_rdata = cur_vec;
    end
  end

  assign fiq_o = line_q && (cur_src == '0);
  assign irq_o = line_q && (cur_src != '0);
endmodule

module vic32_chk #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 6,
  parameter int IW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] mask_q,
  input logic            insvc_q,
  input logic [IW-1:0]   cur_src,
  input logic            irq_o,
  input logic            fiq_o
);
  wire wr_set = bus_wr && bus_addr == AW'(NSRC);
  wire wr_clr = bus_wr && bus_addr == AW'(NSRC + 1);
  wire rd_vec = bus_rd && bus_addr == AW'(NSRC + 4);
  wire wr_eoi = bus_wr && bus_addr == AW'(NSRC + 5);
  wire up     = irq_o || fiq_o;

  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> mask_q == ($past(mask_q) | $past(bus_wdata[NSRC-1:0])));
  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> mask_q == ($past(mask_q) & ~$past(bus_wdata[NSRC-1:0])));
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!insvc_q && |(src_req & mask_q) && !wr_eoi) |=> up);
  p_one_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o));
  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && up && !wr_eoi) |=> !up);
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_q && !up && !wr_eoi) |=> !up);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !rd_vec && !wr_eoi) |=> up && $stable(cur_src));
endmodule

bind vic32 vic32_chk #(.NSRC(NSRC), .DW(DW), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .src_req(src_req),
  .mask_q(mask_q), .insvc_q(insvc_q), .cur_src(cur_src),
  .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/vic32_test.sv
module vic32_test;
  localparam int A_SET = 32, A_CLR = 33, A_MASK = 34, A_SRC = 35, A_VEC = 36, A_EOI = 37;

  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] src_req = 0;
  logic        irq_o, fiq_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] mask_m;
  logic [31:0] vec_m [32];

  vic32 uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_req(src_req), .irq_o(irq_o), .fiq_o(fiq_o));

  always #2 clk = ~clk;

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = 6'(a);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic lines(input string req, input int idx);
    chk(req, {30'd0, fiq_o, irq_o}, (idx < 0) ? 32'd0 : (idx == 0) ? 32'd2 : 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1f3a));
    repeat (3) @(negedge clk);
    rst_n = 1;
    mask_m = 0;
    for (int i = 0; i < 32; i++) vec_m[i] = 0;

    // R1 reset state
    rd(A_MASK, d); chk("R1 mask", d, 0);
    rd(A_SRC, d);  chk("R1 src", d, 0);
    rd(A_VEC, d);  chk("R1 vec", d, 0);
    lines("R1 lines", -1);

    // R2 vector read back
    for (int i = 0; i < 32; i++) begin vec_m[i] = $urandom(); wr(i, vec_m[i]); end
    for (int i = 0; i < 32; i += 7) begin rd(i, d); chk("R2 vector rw", d, vec_m[i]); end

    // R3 / R4 mask set and clear
    wr(A_SET, 32'h0000_00F0); wr(A_SET, 32'h0000_0F00);
    rd(A_MASK, d); chk("R3 set ORs", d, 32'h0000_0FF0);
    wr(A_CLR, 32'h0000_0330);
    rd(A_MASK, d); chk("R4 clear", d, 32'h0000_0CC0);
    mask_m = 32'h0000_0CC0;

    // R5 masked request ignored
    @(negedge clk); src_req = 32'h0000_3001;
    repeat (3) @(negedge clk);
    lines("R5 masked", -1);

    // R6/R8/R10 priority, ack, quiet, re-evaluation
    src_req = 32'h0000_0880;
    repeat (2) @(negedge clk);
    lines("R6 raise", 7);
    rd(A_SRC, d); chk("R6 lowest index", d, 7);
    // R9 write to vector word ignored
    wr(A_VEC, 32'hDEAD_BEEF);
    lines("R9 line kept", 7);
    rd(A_VEC, d); chk("R9 vector kept", d, vec_m[7]);
    lines("R8 ack drops", -1);
    repeat (3) @(negedge clk);
    lines("R8 quiet before eoi", -1);
    src_req = 32'h0000_0800;
    wr(A_EOI, 32'hFFFF_FFFF);
    @(negedge clk);
    lines("R10 reassert", 11);
    rd(A_SRC, d); chk("R10 next source", d, 11);
    rd(A_MASK, d); chk("R10 mask kept", d, mask_m);
    rd(5, d); chk("R10 vector kept", d, vec_m[5]);
    rd(A_VEC, d); chk("R6 vector", d, vec_m[11]);

    // R7 source 0 on fast line
    src_req = 0;
    wr(A_SET, 32'h1); mask_m |= 32'h1;
    src_req = 32'h0000_0801;
    wr(A_EOI, 0);
    @(negedge clk);
    lines("R7 fast line", 0);
    rd(A_VEC, d); chk("R7 vector", d, vec_m[0]);

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [31:0] s, c;
      int w;
      src_req = 0;
      wr(A_EOI, 0);
      for (int k = 0; k < 4; k++) begin
        w = $urandom_range(31);
        vec_m[w] = $urandom(); wr(w, vec_m[w]);
      end
      s = $urandom(); c = $urandom();
      wr(A_SET, s); mask_m |= s;
      wr(A_CLR, c); mask_m &= ~c;
      rd(A_MASK, d); chk("R3 R4 random mask", d, mask_m);
      @(negedge clk);
      src_req = $urandom() & $urandom() & $urandom();
      repeat (2) @(negedge clk);
      w = lowest(src_req & mask_m);
      lines("R5 R6 R7 random lines", w);
      if (w >= 0) begin
        rd(A_SRC, d); chk("R6 random src", d, 32'(w));
        rd(A_VEC, d); chk("R6 random vec", d, vec_m[w]);
        lines("R8 random ack", -1);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule